// File: doc/BRIEF.md
# Serial ROM Command Dispatcher with Identity CRC

This block sits behind a bit-level bus front end that has already put the line's bits together into bytes. After each bus reset it takes the first received byte as a ROM-level function code. It works out which of the eight functions was requested and tracks two flags: the high-speed (overdrive) flag and the resume flag. It also decides whether the device has become addressed, so that a following control-function command may be taken. For an address-match function it compares the next eight bytes with its own 64-bit identity. For the two search functions it waits for a verdict from an external search engine, since the tree walk itself is outside this block.

The identity is held as a parameter word. Its low byte is the family code 29h, the next 48 bits are a serial number, and the top byte is a CRC-8 over the lower 56 bits. After the block's own reset, a bit-serial CRC-8 engine walks all 64 identity bits, least significant first. It then reports whether the register came out at zero, which shows that the stored identity is consistent.

Top module: `rom_dispatch_top`

## Requirements
- R1: After `rst` the block is idle: `cmd_code`=0, `ctrl_en`=0, `od_mode`=0, `resume_flag`=0, and bytes are ignored until the first `bus_rst` pulse.
- R2: The first byte after a bus reset sets `cmd_code`: 33h→1, 55h→2, F0h→3, CCh→4, ECh→5, 69h→6, 3Ch→7, A5h→8.
- R3: Any other first byte sets `cmd_code`=9 and parks the block idle with `ctrl_en`=0 until the next bus reset.
- R4: Codes 33h, CCh and 3Ch raise `ctrl_en` in the cycle after the byte and clear `resume_flag`.
- R5: After 55h or 69h, the next eight bytes are compared with the identity, byte 0 (bits 7:0) first. If all eight match, `ctrl_en` and `resume_flag` are set; any mismatch leaves `ctrl_en`=0 and clears `resume_flag`.
- R6: After F0h or ECh, the block waits for `srch_done`. If `srch_hit`=1, `ctrl_en` and `resume_flag` are set; otherwise it goes idle and clears `resume_flag`.
- R7: Code A5h raises `ctrl_en` only while `resume_flag` is 1. Otherwise the block goes idle.
- R8: Codes 69h and 3Ch set `od_mode`. Only a bus reset with `bus_rst_long`=1 clears it; a short bus reset leaves it unchanged.
- R9: Bytes that arrive while `ctrl_en` is 1, or while idle, change none of `cmd_code`, `od_mode`, `resume_flag` or `ctrl_en`.
- R10: The identity word is {CRC, serial, 29h}. By default the CRC is x^8+x^5+x^4+1 over the low 56 bits, fed LSB first from a zero start.
- R11: `crc_done` rises after the 64 identity bits have been shifted and then stays high. `crc_ok` is 1 exactly when the CRC register is then all zeros.
- R12: A `bus_rst` pulse drops `ctrl_en` in the next cycle and returns the block to waiting for a function code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst | input | 1 | One-cycle pulse: a bus reset was seen |
| bus_rst_long | input | 1 | Qualifies `bus_rst`: reset was of standard-speed length |
| byte_valid | input | 1 | One-cycle strobe for `byte_data` |
| byte_data | input | 8 | Received byte |
| srch_done | input | 1 | External search engine finished |
| srch_hit | input | 1 | With `srch_done`: this device won the search |
| cmd_code | output | 4 | Last decoded function (encoding in R2/R3) |
| ctrl_en | output | 1 | Device addressed; control functions may follow |
| od_mode | output | 1 | High-speed mode flag |
| resume_flag | output | 1 | Resume permission flag |
| crc_done | output | 1 | Identity CRC walk finished |
| crc_ok | output | 1 | Identity CRC residue is zero |

## Verification
The bench builds two instances with the default family code and one fixed serial number. The first uses the derived CRC byte; the second uses that byte with its low bit flipped, which brings both outcomes of the identity check within reach. With this configuration a sweep over all 256 first-byte values, each preceded by a long bus reset, can cover every decode outcome and the overdrive entry in one pass. Directed sequences then exercise address matching, with a mismatch placed at the last byte, both search verdicts, the resume gate and reset lengths.

// File: rtl/rom_pkg.sv
package rom_pkg;

    localparam int ID_BYTES = 8;
    localparam int ID_W     = ID_BYTES * 8;
    localparam int BODY_W   = ID_W - 8;

    localparam logic [7:0] OP_READ     = 8'h33;
    localparam logic [7:0] OP_MATCH    = 8'h55;
    localparam logic [7:0] OP_SEARCH   = 8'hF0;
    localparam logic [7:0] OP_SKIP     = 8'hCC;
    localparam logic [7:0] OP_COND     = 8'hEC;
    localparam logic [7:0] OP_OD_MATCH = 8'h69;
    localparam logic [7:0] OP_OD_SKIP  = 8'h3C;
    localparam logic [7:0] OP_RESUME   = 8'hA5;

    // Reflected form of x^8+x^5+x^4+1 for an LSB-first register
    localparam logic [7:0] CRC_POLY_REFL = 8'h8C;

    typedef enum logic [3:0] {
        RC_NONE     = 4'd0,
        RC_READ     = 4'd1,
        RC_MATCH    = 4'd2,
        RC_SEARCH   = 4'd3,
        RC_SKIP     = 4'd4,
        RC_COND     = 4'd5,
        RC_OD_MATCH = 4'd6,
        RC_OD_SKIP  = 4'd7,
        RC_RESUME   = 4'd8,
        RC_BAD      = 4'd9
    } rom_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_CMD,
        ST_MATCH,
        ST_SEARCH,
        ST_CTRL
    } disp_state_e;

    typedef struct packed {
        rom_cmd_e cmd;
        logic     sets_od;
        logic     is_match;
        logic     is_search;
        logic     direct_ctrl;
    } cmd_info_t;

    function automatic cmd_info_t decode_op(input logic [7:0] op);
        cmd_info_t r;
        r = '{cmd: RC_BAD, sets_od: 1'b0, is_match: 1'b0, is_search: 1'b0, direct_ctrl: 1'b0};
        case (op)
            OP_READ:     begin r.cmd = RC_READ;     r.direct_ctrl = 1'b1; end
            OP_MATCH:    begin r.cmd = RC_MATCH;    r.is_match    = 1'b1; end
            OP_SEARCH:   begin r.cmd = RC_SEARCH;   r.is_search   = 1'b1; end
            OP_SKIP:     begin r.cmd = RC_SKIP;     r.direct_ctrl = 1'b1; end
            OP_COND:     begin r.cmd = RC_COND;     r.is_search   = 1'b1; end
            OP_OD_MATCH: begin r.cmd = RC_OD_MATCH; r.is_match    = 1'b1; r.sets_od = 1'b1; end
            OP_OD_SKIP:  begin r.cmd = RC_OD_SKIP;  r.direct_ctrl = 1'b1; r.sets_od = 1'b1; end
            OP_RESUME:   r.cmd = RC_RESUME;
            default:     r.cmd = RC_BAD;
        endcase
        return r;
    endfunction

    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return {1'b0, c[7:1]} ^ (fb ? CRC_POLY_REFL : 8'h00);
    endfunction

    function automatic logic [7:0] crc8_body(input logic [7:0] fam, input logic [47:0] ser);
        logic [BODY_W-1:0] body;
        logic [7:0]        c;
        body = {ser, fam};
        c    = 8'h00;
        for (int i = 0; i < BODY_W; i++) begin
            c = crc8_step(c, body[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/crc8_serial.sv
module crc8_serial
    import rom_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       din,
    output logic [7:0] crc
);

    logic [7:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= 8'h00;
        end else if (en) begin
            crc_q <= crc8_step(crc_q, din);
        end
    end

    assign crc = crc_q;

    // R11: the register only moves while bits are being fed
    p_hold_when_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(crc_q));

endmodule

// File: rtl/id_crc_scan.sv
module id_crc_scan
    import rom_pkg::*;
#(
    parameter int N_BITS = ID_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_BITS-1:0] id_word,
    output logic              done,
    output logic              ok
);

    localparam int CW = $clog2(N_BITS + 1);
    localparam int IW = $clog2(N_BITS);

    logic [CW-1:0] cnt_q;
    logic          feed;
    logic [7:0]    residue;

    assign feed = (cnt_q != CW'(N_BITS));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (feed) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    crc8_serial u_crc (
        .clk (clk),
        .rst (rst),
        .en  (feed),
        .din (id_word[cnt_q[IW-1:0]]),
        .crc (residue)
    );

    assign done = !feed;
    assign ok   = done && (residue == 8'h00);

    // R11: once finished the walk never restarts without reset
    p_done_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R11: verdict is frozen once the walk is over
    p_ok_stable_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(ok));

endmodule

// File: rtl/rom_cmd_fsm.sv
module rom_cmd_fsm
    import rom_pkg::*;
#(
    parameter int N_BYTES = ID_BYTES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_rst,
    input  logic                 bus_rst_long,
    input  logic                 byte_valid,
    input  logic [7:0]           byte_data,
    input  logic                 srch_done,
    input  logic                 srch_hit,
    input  logic [N_BYTES*8-1:0] id_word,
    output logic [3:0]           cmd_code,
    output logic                 ctrl_en,
    output logic                 od_mode,
    output logic                 resume_flag
);

    localparam int BW = $clog2(N_BYTES);
    localparam logic [BW-1:0] LAST_IDX = BW'(N_BYTES - 1);

    disp_state_e state_q;
    rom_cmd_e    cmd_q;
    logic        od_q;
    logic        res_q;
    logic [BW-1:0] idx_q;
    logic        miss_q;
    cmd_info_t   info;
    logic [7:0]  id_bytes [N_BYTES];
    logic        byte_hit;

    for (genvar g = 0; g < N_BYTES; g++) begin : g_id_bytes
        assign id_bytes[g] = id_word[g*8 +: 8];
    end

    assign info     = decode_op(byte_data);
    assign byte_hit = (byte_data == id_bytes[idx_q]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cmd_q   <= RC_NONE;
            od_q    <= 1'b0;
            res_q   <= 1'b0;
            idx_q   <= '0;
            miss_q  <= 1'b0;
        end else if (bus_rst) begin
            state_q <= ST_WAIT_CMD;
            idx_q   <= '0;
            miss_q  <= 1'b0;
            if (bus_rst_long) begin
                od_q <= 1'b0;
            end
        end else begin
            case (state_q)
                ST_WAIT_CMD: begin
                    if (byte_valid) begin
                        cmd_q <= info.cmd;
                        if (info.sets_od) begin
                            od_q <= 1'b1;
                        end
                        if (info.is_match) begin
                            state_q <= ST_MATCH;
                            idx_q   <= '0;
                            miss_q  <= 1'b0;
                        end else if (info.is_search) begin
                            state_q <= ST_SEARCH;
                        end else if (info.direct_ctrl) begin
                            state_q <= ST_CTRL;
                            res_q   <= 1'b0;
                        end else if (info.cmd == RC_RESUME) begin
                            state_q <= res_q ? ST_CTRL : ST_IDLE;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_MATCH: begin
                    if (byte_valid) begin
                        if (idx_q == LAST_IDX) begin
                            if (miss_q || !byte_hit) begin
                                state_q <= ST_IDLE;
                                res_q   <= 1'b0;
                            end else begin
                                state_q <= ST_CTRL;
                                res_q   <= 1'b1;
                            end
                        end else begin
                            idx_q  <= idx_q + 1'b1;
                            miss_q <= miss_q | !byte_hit;
                        end
                    end
                end
                ST_SEARCH: begin
                    if (srch_done) begin
                        state_q <= srch_hit ? ST_CTRL : ST_IDLE;
                        res_q   <= srch_hit;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign cmd_code    = cmd_q;
    assign ctrl_en     = (state_q == ST_CTRL);
    assign od_mode     = od_q;
    assign resume_flag = res_q;

    // R8: a standard-length bus reset leaves standard speed in force
    p_long_rst_clears_od_r8: assert property (@(posedge clk) disable iff (rst)
        bus_rst && bus_rst_long |=> !od_mode);

    // R8: a short bus reset keeps the speed flag
    p_short_rst_keeps_od_r8: assert property (@(posedge clk) disable iff (rst)
        bus_rst && !bus_rst_long |=> $stable(od_q));

    // R8: speed flag is raised only by an overdrive function byte
    p_od_source_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(od_q) |-> $past(byte_valid && state_q == ST_WAIT_CMD &&
                              (byte_data == OP_OD_MATCH || byte_data == OP_OD_SKIP)));

    // R7: resume without permission parks the block
    p_resume_gate_r7: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_WAIT_CMD && byte_valid && byte_data == OP_RESUME && !res_q && !bus_rst
        |=> state_q == ST_IDLE);

    // R12: every bus reset returns to waiting for a function code
    p_bus_rst_r12: assert property (@(posedge clk) disable iff (rst)
        bus_rst |=> state_q == ST_WAIT_CMD);

    // R9: addressed state ignores bytes until the next bus reset
    p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_CTRL && !bus_rst |=> state_q == ST_CTRL && $stable(cmd_q) && $stable(res_q));

endmodule

// File: rtl/rom_dispatch_top.sv
module rom_dispatch_top
    import rom_pkg::*;
#(
    parameter logic [7:0]  FAMILY = 8'h29,
    parameter logic [47:0] SERIAL = 48'h0000_1234_5678,
    parameter logic [7:0]  ID_CRC = crc8_body(FAMILY, SERIAL)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_rst,
    input  logic       bus_rst_long,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       srch_done,
    input  logic       srch_hit,
    output logic [3:0] cmd_code,
    output logic       ctrl_en,
    output logic       od_mode,
    output logic       resume_flag,
    output logic       crc_done,
    output logic       crc_ok
);

    // R10: identity word, family code in the low byte
    logic [ID_W-1:0] id_word;
    assign id_word = {ID_CRC, SERIAL, FAMILY};

    rom_cmd_fsm #(.N_BYTES(ID_BYTES)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .bus_rst      (bus_rst),
        .bus_rst_long (bus_rst_long),
        .byte_valid   (byte_valid),
        .byte_data    (byte_data),
        .srch_done    (srch_done),
        .srch_hit     (srch_hit),
        .id_word      (id_word),
        .cmd_code     (cmd_code),
        .ctrl_en      (ctrl_en),
        .od_mode      (od_mode),
        .resume_flag  (resume_flag)
    );

    id_crc_scan #(.N_BITS(ID_W)) u_scan (
        .clk     (clk),
        .rst     (rst),
        .id_word (id_word),
        .done    (crc_done),
        .ok      (crc_ok)
    );

endmodule

// File: tb/tb_rom_dispatch_top.sv
module tb_rom_dispatch_top;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [7:0]  FAM = 8'h29;
    localparam logic [47:0] SER = 48'h0000_1234_5678;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_rst = 1'b0;
    logic       bus_rst_long = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       srch_done = 1'b0;
    logic       srch_hit = 1'b0;

    logic [3:0] cmd_code, cmd_code_b;
    logic       ctrl_en, ctrl_en_b, od_mode, od_mode_b, resume_flag, resume_flag_b;
    logic       crc_done, crc_done_b, crc_ok, crc_ok_b;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Independent byte-wise CRC model: LSB first, reflected x^8+x^5+x^4+1
    function automatic logic [7:0] ref_crc(input logic [55:0] body);
        logic [7:0] c = 8'h00;
        for (int k = 0; k < 7; k++) begin
            c = c ^ body[k*8 +: 8];
            for (int j = 0; j < 8; j++) begin
                c = c[0] ? ((c >> 1) ^ 8'h8C) : (c >> 1);
            end
        end
        return c;
    endfunction

    localparam logic [7:0] GOOD_CRC = ref_crc({SER, FAM});
    localparam logic [63:0] IDENT = {GOOD_CRC, SER, FAM};

    rom_dispatch_top dut (
        .clk(clk), .rst(rst), .bus_rst(bus_rst), .bus_rst_long(bus_rst_long),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .srch_done(srch_done), .srch_hit(srch_hit),
        .cmd_code(cmd_code), .ctrl_en(ctrl_en), .od_mode(od_mode),
        .resume_flag(resume_flag), .crc_done(crc_done), .crc_ok(crc_ok)
    );

    rom_dispatch_top #(.FAMILY(FAM), .SERIAL(SER), .ID_CRC(GOOD_CRC ^ 8'h01)) dut_bad (
        .clk(clk), .rst(rst), .bus_rst(bus_rst), .bus_rst_long(bus_rst_long),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .srch_done(srch_done), .srch_hit(srch_hit),
        .cmd_code(cmd_code_b), .ctrl_en(ctrl_en_b), .od_mode(od_mode_b),
        .resume_flag(resume_flag_b), .crc_done(crc_done_b), .crc_ok(crc_ok_b)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_bus_rst(input logic is_long);
        @(negedge clk);
        bus_rst = 1'b1;
        bus_rst_long = is_long;
        @(negedge clk);
        bus_rst = 1'b0;
        bus_rst_long = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic search_result(input logic hit);
        @(negedge clk);
        srch_done = 1'b1;
        srch_hit = hit;
        @(negedge clk);
        srch_done = 1'b0;
        srch_hit = 1'b0;
    endtask

    function automatic logic [3:0] exp_code(input logic [7:0] b);
        case (b)
            8'h33: return 4'd1;
            8'h55: return 4'd2;
            8'hF0: return 4'd3;
            8'hCC: return 4'd4;
            8'hEC: return 4'd5;
            8'h69: return 4'd6;
            8'h3C: return 4'd7;
            8'hA5: return 4'd8;
            default: return 4'd9;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state, then a byte before any bus reset is ignored
        check("R1 cmd_code", cmd_code, 0);
        check("R1 ctrl_en", ctrl_en, 0);
        check("R1 od_mode", od_mode, 0);
        check("R1 resume_flag", resume_flag, 0);
        send_byte(8'h33);
        check("R1 byte before bus reset", {cmd_code, ctrl_en}, {4'd0, 1'b0});

        // R11 / R10: identity CRC walk
        repeat (70) @(negedge clk);
        check("R11 crc_done", crc_done, 1);
        check("R11 crc_ok good identity", crc_ok, 1);
        check("R11 crc_done bad", crc_done_b, 1);
        check("R11 crc_ok bad identity", crc_ok_b, 0);

        // R2 R3 R4 R8: sweep every first byte after a long bus reset
        for (int c = 0; c < 256; c++) begin
            logic [3:0] ec;
            logic ectrl, eod;
            pulse_bus_rst(1'b1);
            check("R12 ctrl_en after bus reset", ctrl_en, 0);
            send_byte(c[7:0]);
            ec = exp_code(c[7:0]);
            ectrl = (c == 8'h33) || (c == 8'hCC) || (c == 8'h3C);
            eod = (c == 8'h69) || (c == 8'h3C);
            check(ec == 4'd9 ? "R3 code" : "R2 code", cmd_code, ec);
            check("R4 R7 ctrl_en", ctrl_en, ectrl);
            check("R8 od_mode", od_mode, eod);
            check("R4 resume_flag", resume_flag, 0);
        end

        // R3: idle after unknown code ignores a valid code
        pulse_bus_rst(1'b1);
        send_byte(8'h00);
        send_byte(8'hCC);
        check("R3 idle ignores byte", {cmd_code, ctrl_en}, {4'd9, 1'b0});

        // R5 R10: full identity match
        pulse_bus_rst(1'b1);
        send_byte(8'h55);
        for (int k = 0; k < 8; k++) begin
            if (k == 7) check("R5 not yet addressed", ctrl_en, 0);
            send_byte(IDENT[k*8 +: 8]);
        end
        check("R5 R10 match ctrl_en", ctrl_en, 1);
        check("R5 match resume_flag", resume_flag, 1);

        // R9: bytes while addressed have no effect
        send_byte(8'h3C);
        check("R9 ctrl ignores byte", {cmd_code, od_mode, resume_flag, ctrl_en}, {4'd2, 1'b0, 1'b1, 1'b1});

        // R7: resume honoured with flag set
        pulse_bus_rst(1'b0);
        send_byte(8'hA5);
        check("R7 resume accepted", {cmd_code, ctrl_en}, {4'd8, 1'b1});

        // R4: skip clears the flag; resume then refused
        pulse_bus_rst(1'b0);
        send_byte(8'hCC);
        check("R4 skip clears resume", resume_flag, 0);
        pulse_bus_rst(1'b0);
        send_byte(8'hA5);
        check("R7 resume refused", ctrl_en, 0);

        // R6: search win then search loss
        pulse_bus_rst(1'b1);
        send_byte(8'hF0);
        check("R6 waiting for search", ctrl_en, 0);
        search_result(1'b1);
        check("R6 search hit", {ctrl_en, resume_flag}, 2'b11);
        pulse_bus_rst(1'b1);
        send_byte(8'hEC);
        search_result(1'b0);
        check("R6 search miss", {ctrl_en, resume_flag}, 2'b00);

        // R5 R8: overdrive match with mismatch in the last byte
        pulse_bus_rst(1'b1);
        search_result(1'b1);
        check("R6 verdict ignored outside search", ctrl_en, 0);
        send_byte(8'hF0);
        search_result(1'b1);
        pulse_bus_rst(1'b1);
        send_byte(8'h69);
        check("R8 od after od-match", od_mode, 1);
        for (int k = 0; k < 8; k++) begin
            send_byte(k == 7 ? (IDENT[k*8 +: 8] ^ 8'h80) : IDENT[k*8 +: 8]);
        end
        check("R5 mismatch ctrl_en", ctrl_en, 0);
        check("R5 mismatch clears resume", resume_flag, 0);

        // R8: short reset keeps overdrive, long reset drops it
        pulse_bus_rst(1'b0);
        check("R8 short reset keeps od", od_mode, 1);
        pulse_bus_rst(1'b1);
        check("R8 long reset clears od", od_mode, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule